// File: doc/BRIEF.md
# Masked Configuration Register File

This block holds the byte-addressed configuration space of a device: identity fields, a command register and a large device-specific area. Software reaches it through a single request port that carries an address, a byte count of 1, 2 or 4, and write data. Writes are applied byte by byte through a fixed per-byte write mask, so read-only bits keep their value. Reads return little-endian data one cycle after the request. A static mode input chooses between a conventional 256-byte space and an extended 4096-byte space. Accesses that run past the end of the active space are cut short.

A second port restores a saved image of the space, for example after a state migration. The image is streamed one byte per cycle in a check pass. That pass compares it against the live contents under a check mask and reports pass or fail. A second, apply pass streams the same image again and overwrites every byte, read-only ones included. It does so only if the check passed and no software write has landed since the check began.

Top module: `cfgspace_regfile`

## Requirements
- R1: After reset every byte is zero except the identity fields: vendor id at bytes 0x00-0x01, device id at 0x02-0x03, revision at 0x08, class code at 0x09-0x0B and subsystem vendor/subsystem id at 0x2C-0x2F, all little-endian and taken from parameters.
- R2: Each written byte becomes (old AND NOT mask) OR (data AND mask). The mask is 0x07 at 0x04 (I/O enable bit 0, memory enable bit 1, bus master bit 2), 0xFF at 0x0C and 0x3C, 0xFF for every offset from 0x40 to the end of the space, and 0x00 everywhere else.
- R3: A write of length n (req_len 1, 2, otherwise 4) stores byte k of req_wdata (bits 8k+7:8k) at address req_addr+k, for k from 0 to n-1.
- R4: Write bytes whose address is at or beyond the active space size are dropped and disturb no other byte.
- R5: Read byte lanes whose address is at or beyond the space size, or whose index is not below the length, return zero; in particular a 1-byte read has bits 31:8 zero.
- R6: rsp_valid is high exactly in the cycle after a read request, and rsp_rdata then holds byte req_addr+k in bits 8k+7:8k.
- R7: With ext_mode high the space is 4096 bytes and offsets 0x100-0xFFF behave as writable storage; with ext_mode low it is 256 bytes.
- R8: A check pass streams one image byte per cycle from offset 0 to the last byte of the space (img_valid high, img_apply low). One cycle after the last byte, chk_done pulses for one cycle. chk_pass is low if any byte differs from the current contents in a bit that is checked and not writable. Checked bytes are 0x00-0x05, 0x08-0x0B and 0x2C-0x2F, all bits; writable bits per R2 are never checked.
- R9: After a passing check, an apply pass (img_apply high) stores each streamed byte unmasked at its offset, read-only bytes included. Without a passing check, apply bytes are dropped.
- R10: A software write that stores any byte between the start of a check pass and the end of the apply pass cancels the apply, even in the cycle of the last check byte. The check still compares against the contents as they were before that cycle's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ext_mode | input | 1 | Static: 1 selects the 4096-byte space, 0 the 256-byte space |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 12 | Byte address |
| req_len | input | 3 | Byte count: 1, 2, else 4 |
| req_wdata | input | 32 | Write data, byte 0 in bits 7:0 |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Little-endian read data |
| img_valid | input | 1 | Image byte strobe |
| img_apply | input | 1 | 0 check pass, 1 apply pass |
| img_data | input | 8 | Image byte |
| chk_done | output | 1 | One-cycle pulse after the last check byte |
| chk_pass | output | 1 | Check verdict, valid with chk_done |

## Verification
A software write can land in the same cycle as an image byte. The bench provokes this by issuing a write to offset 0xFF while the last check byte, also for offset 0xFF, is presented with the old value. It expects a passing verdict, because the compare sees pre-write contents. It also expects the next apply pass to change nothing, so reads show the written byte and none of the image. A separate property forbids an apply byte and a software byte store in the same cycle.

// File: rtl/cfgspace_pkg.sv
package cfgspace_pkg;

  localparam int unsigned HDR_END  = 'h40;
  localparam int unsigned OFF_CMD  = 'h04;
  localparam int unsigned OFF_CLS  = 'h0C;
  localparam int unsigned OFF_IRQ  = 'h3C;
  localparam logic [7:0]  CMD_WBITS = 8'h07;

  typedef enum logic {PH_CHECK = 1'b0, PH_APPLY = 1'b1} img_phase_e;

  // bits software may change at a given offset
  function automatic logic [7:0] wmask_at(input int unsigned off);
    if (off >= HDR_END)                    return 8'hFF;
    else if (off == OFF_CMD)               return CMD_WBITS;
    else if (off == OFF_CLS || off == OFF_IRQ) return 8'hFF;
    else                                   return 8'h00;
  endfunction

  // bits compared when an image is checked
  function automatic logic [7:0] cmask_at(input int unsigned off);
    if (off <= 'h05)                       return 8'hFF;
    else if (off >= 'h08 && off <= 'h0B)   return 8'hFF;
    else if (off >= 'h2C && off <= 'h2F)   return 8'hFF;
    else                                   return 8'h00;
  endfunction

endpackage

// File: rtl/cfg_lane_ctl.sv
module cfg_lane_ctl #(
  parameter int AW    = 12,
  parameter int LANES = 4
) (
  input  logic [AW-1:0]            addr,
  input  logic [2:0]               len,
  input  logic [AW:0]              space_size,
  output logic [LANES-1:0]         lane_en,
  output logic [LANES-1:0][AW-1:0] lane_addr
);
  localparam int LW = $clog2(LANES) + 1;

  logic [LW-1:0] nbytes;

  always_comb begin
    if (len == 3'd1)      nbytes = LW'(1);
    else if (len == 3'd2) nbytes = LW'(2);
    else                  nbytes = LW'(LANES);
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [AW:0] sum;
    assign sum          = {1'b0, addr} + (AW+1)'(k);
    assign lane_en[k]   = (LW'(k) < nbytes) && (sum < space_size);
    assign lane_addr[k] = sum[AW-1:0];
  end

endmodule

// File: rtl/cfg_image_seq.sv
module cfg_image_seq
  import cfgspace_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW:0]   space_size,
  input  logic          img_valid,
  input  img_phase_e    img_phase,
  input  logic [7:0]    img_data,
  input  logic [7:0]    cur_byte,
  input  logic          sw_write,
  output logic [AW-1:0] pos,
  output logic          apply_fire,
  output logic          chk_done,
  output logic          chk_pass
);
  logic [AW-1:0] pos_q, pos_n;
  logic bad_q, bad_n, dirty_q, dirty_n, armed_q, armed_n;
  logic done_q, done_n, pass_q, pass_n;
  logic last, bad_now, check_fire;

  assign last       = ({1'b0, pos_q} == space_size - (AW+1)'(1));
  assign bad_now    = |((img_data ^ cur_byte) & cmask_at(32'(pos_q)) & ~wmask_at(32'(pos_q)));
  assign check_fire = img_valid && (img_phase == PH_CHECK);
  assign apply_fire = img_valid && (img_phase == PH_APPLY) && armed_q && !sw_write;

  always_comb begin
    pos_n   = pos_q;
    bad_n   = bad_q;
    dirty_n = dirty_q | sw_write;
    armed_n = armed_q;
    done_n  = 1'b0;
    pass_n  = pass_q;
    if (img_valid) pos_n = last ? '0 : pos_q + AW'(1);
    if (check_fire) begin
      if (pos_q == '0) begin
        bad_n   = bad_now;
        dirty_n = sw_write;
        armed_n = 1'b0;
      end else begin
        bad_n = bad_q | bad_now;
      end
      if (last) begin
        done_n  = 1'b1;
        pass_n  = !bad_n;
        armed_n = !bad_n && !dirty_n;
      end
    end
    if (img_valid && img_phase == PH_APPLY && last) armed_n = 1'b0;
    if (sw_write) armed_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      bad_q   <= 1'b0;
      dirty_q <= 1'b0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
    end else begin
      if (img_valid) pos_q <= pos_n;
      bad_q   <= bad_n;
      dirty_q <= dirty_n;
      armed_q <= armed_n;
      done_q  <= done_n;
      if (done_n) pass_q <= pass_n;
    end
  end

  assign pos      = pos_q;
  assign chk_done = done_q;
  assign chk_pass = pass_q;

endmodule

// File: rtl/cfg_byte_store.sv
module cfg_byte_store
  import cfgspace_pkg::*;
#(
  parameter int          AW            = 12,
  parameter int          LANES         = 4,
  parameter logic [15:0] VENDOR_ID     = 16'h0000,
  parameter logic [15:0] DEVICE_ID     = 16'h0000,
  parameter logic [7:0]  REVISION      = 8'h00,
  parameter logic [23:0] CLASS_CODE    = 24'h000000,
  parameter logic [15:0] SUBSYS_VENDOR = 16'h0000,
  parameter logic [15:0] SUBSYS_ID     = 16'h0000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LANES-1:0]         wr_en,
  input  logic [LANES-1:0][AW-1:0] lane_addr,
  input  logic [8*LANES-1:0]       wdata,
  input  logic                     apply_fire,
  input  logic [AW-1:0]            apply_addr,
  input  logic [7:0]               apply_data,
  output logic [LANES-1:0][7:0]    rd_byte,
  output logic [7:0]               chk_byte
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];
  logic [LANES-1:0][7:0] merged;

  function automatic logic [7:0] rst_byte(input int unsigned off);
    case (off)
      'h00: return VENDOR_ID[7:0];
      'h01: return VENDOR_ID[15:8];
      'h02: return DEVICE_ID[7:0];
      'h03: return DEVICE_ID[15:8];
      'h08: return REVISION;
      'h09: return CLASS_CODE[7:0];
      'h0A: return CLASS_CODE[15:8];
      'h0B: return CLASS_CODE[23:16];
      'h2C: return SUBSYS_VENDOR[7:0];
      'h2D: return SUBSYS_VENDOR[15:8];
      'h2E: return SUBSYS_ID[7:0];
      'h2F: return SUBSYS_ID[15:8];
      default: return 8'h00;
    endcase
  endfunction

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      merged[k]  = (mem[lane_addr[k]] & ~wmask_at(32'(lane_addr[k]))) |
                   (wdata[8*k +: 8] & wmask_at(32'(lane_addr[k])));
      rd_byte[k] = mem[lane_addr[k]];
    end
    chk_byte = mem[apply_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= rst_byte(i);
    end else begin
      if (apply_fire) mem[apply_addr] <= apply_data;
      for (int k = 0; k < LANES; k++)
        if (wr_en[k]) mem[lane_addr[k]] <= merged[k];
    end
  end

endmodule

// File: rtl/cfgspace_regfile.sv
module cfgspace_regfile
  import cfgspace_pkg::*;
#(
  parameter int          BASE_BYTES    = 256,
  parameter int          EXT_BYTES     = 4096,
  parameter logic [15:0] VENDOR_ID     = 16'h1234,
  parameter logic [15:0] DEVICE_ID     = 16'h5678,
  parameter logic [7:0]  REVISION      = 8'h01,
  parameter logic [23:0] CLASS_CODE    = 24'h020000,
  parameter logic [15:0] SUBSYS_VENDOR = 16'h1234,
  parameter logic [15:0] SUBSYS_ID     = 16'h0001,
  localparam int         AW            = $clog2(EXT_BYTES),
  localparam int         LANES         = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_mode,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [2:0]    req_len,
  input  logic [31:0]   req_wdata,
  output logic          rsp_valid,
  output logic [31:0]   rsp_rdata,
  input  logic          img_valid,
  input  logic          img_apply,
  input  logic [7:0]    img_data,
  output logic          chk_done,
  output logic          chk_pass
);
  logic [AW:0]               space_size;
  logic [LANES-1:0]          lane_en, wr_en;
  logic [LANES-1:0][AW-1:0]  lane_addr;
  logic [LANES-1:0][7:0]     rd_byte;
  logic [7:0]                chk_byte;
  logic [AW-1:0]             img_pos;
  logic                      apply_fire, sw_write, rd_fire;
  logic [31:0]               rd_word_n, rdata_q;
  logic                      rvalid_q;
  img_phase_e                phase;

  assign space_size = ext_mode ? (AW+1)'(EXT_BYTES) : (AW+1)'(BASE_BYTES);
  assign wr_en      = lane_en & {LANES{req_valid && req_write}};
  assign sw_write   = |wr_en;
  assign rd_fire    = req_valid && !req_write;
  assign phase      = img_apply ? PH_APPLY : PH_CHECK;

  cfg_lane_ctl #(.AW(AW), .LANES(LANES)) u_lanes (
    .addr(req_addr), .len(req_len), .space_size(space_size),
    .lane_en(lane_en), .lane_addr(lane_addr)
  );

  cfg_image_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .space_size(space_size),
    .img_valid(img_valid), .img_phase(phase), .img_data(img_data),
    .cur_byte(chk_byte), .sw_write(sw_write), .pos(img_pos),
    .apply_fire(apply_fire), .chk_done(chk_done), .chk_pass(chk_pass)
  );

  cfg_byte_store #(
    .AW(AW), .LANES(LANES), .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID),
    .REVISION(REVISION), .CLASS_CODE(CLASS_CODE),
    .SUBSYS_VENDOR(SUBSYS_VENDOR), .SUBSYS_ID(SUBSYS_ID)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .lane_addr(lane_addr),
    .wdata(req_wdata), .apply_fire(apply_fire), .apply_addr(img_pos),
    .apply_data(img_data), .rd_byte(rd_byte), .chk_byte(chk_byte)
  );

  always_comb begin
    for (int k = 0; k < LANES; k++)
      rd_word_n[8*k +: 8] = lane_en[k] ? rd_byte[k] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_fire;
      if (rd_fire) rdata_q <= rd_word_n;
    end
  end

  assign rsp_valid = rvalid_q;
  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/cfgspace_regfile_chk.sv
module cfgspace_regfile_chk #(
  parameter int AW         = 12,
  parameter int BASE_BYTES = 256,
  parameter int LANES      = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ext_mode,
  input logic             req_valid,
  input logic             req_write,
  input logic [AW-1:0]    req_addr,
  input logic [2:0]       req_len,
  input logic             rsp_valid,
  input logic [31:0]      rsp_rdata,
  input logic             img_valid,
  input logic             img_apply,
  input logic             chk_done,
  input logic             apply_fire,
  input logic [LANES-1:0] wr_en
);
  a_r6_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  a_r6_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  a_r5_byte_read_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_len == 3'd1) |=> (rsp_rdata[31:8] == 24'h0));

  a_r5_outside_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !ext_mode && ({1'b0, req_addr} >= (AW+1)'(BASE_BYTES)))
    |=> (rsp_rdata == 32'h0));

  a_r10_apply_excludes_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(apply_fire && (|wr_en)));

  a_r8_done_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    chk_done |=> !chk_done);

  a_r8_done_after_check_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chk_done) |-> $past(img_valid && !img_apply));

endmodule

bind cfgspace_regfile cfgspace_regfile_chk #(.AW(AW), .BASE_BYTES(BASE_BYTES), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .req_valid(req_valid),
  .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .img_valid(img_valid),
  .img_apply(img_apply), .chk_done(chk_done), .apply_fire(apply_fire),
  .wr_en(wr_en)
);

// File: tb/sim_cfgspace_regfile.sv
module sim_cfgspace_regfile;
  localparam logic [15:0] VID = 16'hA5C3, DID = 16'h7E21, SVID = 16'h5511, SID = 16'h9A02;
  localparam logic [7:0]  REV = 8'h3B;
  localparam logic [23:0] CLS = 24'h0C0330;

  logic clk = 1'b0, rst_n = 1'b0, ext_mode = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [2:0]  req_len = 3'd1;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, chk_done, chk_pass;
  logic [31:0] rsp_rdata;
  logic img_valid = 1'b0, img_apply = 1'b0;
  logic [7:0] img_data = '0;

  int checks = 0, errors = 0, cycles = 0, cur_size = 256;
  logic [7:0] ref_mem [4096];
  logic [7:0] img [4096];

  always #4 clk = ~clk;

  cfgspace_regfile #(.VENDOR_ID(VID), .DEVICE_ID(DID), .REVISION(REV),
    .CLASS_CODE(CLS), .SUBSYS_VENDOR(SVID), .SUBSYS_ID(SID)) u0 (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .img_valid(img_valid), .img_apply(img_apply), .img_data(img_data),
    .chk_done(chk_done), .chk_pass(chk_pass));

  function automatic logic [7:0] wm(input int a);
    if (a >= 'h40) return 8'hFF;
    if (a == 'h04) return 8'h07;
    if (a == 'h0C || a == 'h3C) return 8'hFF;
    return 8'h00;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4096; i++) ref_mem[i] = 8'h00;
    ref_mem[0] = VID[7:0];  ref_mem[1] = VID[15:8];
    ref_mem[2] = DID[7:0];  ref_mem[3] = DID[15:8];
    ref_mem[8] = REV;
    ref_mem[9] = CLS[7:0];  ref_mem[10] = CLS[15:8]; ref_mem[11] = CLS[23:16];
    ref_mem['h2C] = SVID[7:0]; ref_mem['h2D] = SVID[15:8];
    ref_mem['h2E] = SID[7:0];  ref_mem['h2F] = SID[15:8];
  endtask

  task automatic do_reset(input logic ext);
    @(negedge clk); rst_n = 1'b0; ext_mode = ext;
    cur_size = ext ? 4096 : 256;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic int nb(input logic [2:0] len);
    return (len == 3'd1) ? 1 : (len == 3'd2) ? 2 : 4;
  endfunction

  task automatic wr(input int addr, input logic [2:0] len, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'(addr); req_len = len; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    for (int k = 0; k < nb(len); k++)
      if (addr + k < cur_size)
        ref_mem[addr+k] = (ref_mem[addr+k] & ~wm(addr+k)) | (d[8*k +: 8] & wm(addr+k));
  endtask

  task automatic rd(input int addr, input logic [2:0] len, input string tag);
    logic [31:0] exp;
    exp = '0;
    for (int k = 0; k < nb(len); k++)
      if (addr + k < cur_size) exp[8*k +: 8] = ref_mem[addr+k];
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 12'(addr); req_len = len;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid == 1'b1, {tag, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    check(rsp_rdata == exp, tag, rsp_rdata, exp);
  endtask

  task automatic stream(input bit apply, input int col_idx, input int col_addr, input logic [7:0] col_d);
    for (int i = 0; i < cur_size; i++) begin
      @(negedge clk);
      img_valid = 1'b1; img_apply = apply; img_data = img[i];
      if (i == col_idx) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = 12'(col_addr);
        req_len = 3'd1; req_wdata = {24'h0, col_d};
      end else begin
        req_valid = 1'b0; req_write = 1'b0;
      end
    end
    @(negedge clk);
    img_valid = 1'b0; img_apply = 1'b0; req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic copy_ref_to_img();
    for (int i = 0; i < 4096; i++) img[i] = ref_mem[i];
  endtask

  task automatic t_reset();   // R1
    rd('h00, 3'd4, "R1 ids");
    rd('h08, 3'd4, "R1 rev/class");
    rd('h2C, 3'd4, "R1 subsystem");
    rd('h04, 3'd4, "R1 cmd zero");
    rd('h80, 3'd4, "R1 body zero");
  endtask

  task automatic t_wmask();   // R2
    wr('h04, 3'd4, 32'hFFFF_FFFF);
    rd('h04, 3'd4, "R2 cmd bits");
    wr('h0C, 3'd4, 32'hFFFF_FFFF);
    rd('h0C, 3'd4, "R2 cache line only");
    wr('h3C, 3'd4, 32'h1122_3344);
    rd('h3C, 3'd4, "R2 irq line only");
    wr('h00, 3'd4, 32'h0);
    rd('h00, 3'd4, "R2 ids read-only");
    wr('h04, 3'd1, 32'h0000_00FA);
    rd('h04, 3'd1, "R2 cmd partial");
  endtask

  task automatic t_order();   // R3, R6
    wr('h40, 3'd4, 32'h4433_2211);
    rd('h40, 3'd1, "R3 byte0");
    rd('h41, 3'd2, "R6 half");
    rd('h40, 3'd4, "R6 word");
    wr('h50, 3'd2, 32'hDEAD_BEEF);
    rd('h50, 3'd4, "R3 len2 stores two");
    wr('h60, 3'd7, 32'hCAFE_F00D);
    rd('h60, 3'd4, "R3 other len is four");
  endtask

  task automatic t_end();     // R4, R5
    wr('hFE, 3'd4, 32'hA1B2_C3D4);
    rd('hFC, 3'd4, "R4 tail kept");
    rd('hFE, 3'd4, "R5 read cut at end");
    wr('h140, 3'd4, 32'h9999_9999);
    rd('h40, 3'd4, "R4 no alias on drop");
    rd('h140, 3'd4, "R5 beyond end zero");
  endtask

  task automatic t_check_reject();  // R8, R9
    copy_ref_to_img();
    img[4] = img[4] ^ 8'h08;
    stream(1'b0, -1, 0, 8'h0);
    check(chk_done == 1'b1, "R8 done pulse", 32'(chk_done), 32'd1);
    check(chk_pass == 1'b0, "R8 reject checked bit", 32'(chk_pass), 32'd0);
    img[4] = ref_mem[4];
    img['h90] = 8'hEE;
    stream(1'b1, -1, 0, 8'h0);
    rd('h90, 3'd1, "R9 apply dropped after fail");
    rd('h04, 3'd1, "R9 cmd untouched");
  endtask

  task automatic t_check_accept();  // R8, R9
    copy_ref_to_img();
    img[4] = img[4] ^ 8'h05;   // writable bits only
    img['h06] = 8'h5C;         // unchecked read-only byte
    img['h88] = 8'h77;
    stream(1'b0, -1, 0, 8'h0);
    check(chk_done == 1'b1, "R8 done pulse pass", 32'(chk_done), 32'd1);
    check(chk_pass == 1'b1, "R8 writable bits ignored", 32'(chk_pass), 32'd1);
    @(negedge clk);
    check(chk_done == 1'b0, "R8 done one cycle", 32'(chk_done), 32'd0);
    stream(1'b1, -1, 0, 8'h0);
    for (int i = 0; i < cur_size; i++) ref_mem[i] = img[i];
    rd('h04, 3'd4, "R9 raw apply header");
    rd('h88, 3'd1, "R9 apply body");
  endtask

  task automatic t_collide();  // R10
    copy_ref_to_img();
    stream(1'b0, cur_size - 1, 'hFF, 8'h3C);
    ref_mem['hFF] = 8'h3C;
    check(chk_pass == 1'b1, "R10 check sees pre-write data", 32'(chk_pass), 32'd1);
    img['hA0] = 8'h99;
    stream(1'b1, -1, 0, 8'h0);
    rd('hA0, 3'd1, "R10 apply cancelled");
    rd('hFF, 3'd1, "R10 write kept");
  endtask

  task automatic t_ext();   // R7
    do_reset(1'b1);
    rd('h00, 3'd4, "R7 ids in ext mode");
    wr('h100, 3'd4, 32'h0BAD_F00D);
    rd('h100, 3'd4, "R7 ext body writable");
    wr('hFFE, 3'd4, 32'hA1B2_C3D4);
    rd('hFFC, 3'd4, "R7 ext end cut");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=done", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    do_reset(1'b0);
    t_reset();
    t_wmask();
    t_order();
    t_end();
    t_check_reject();
    t_check_accept();
    t_collide();
    t_ext();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule